// File: doc/BRIEF.md
# Operand Forwarding Multiplexer Unit

This block chooses the values that feed the execute stage and the store-data port of the memory stage in a five-stage integer pipeline. It receives the source operands held in the decode/execute pipeline register, the next-instruction address, the newest ALU result (execute/memory register), and both the ALU result and the loaded word sitting in the memory/writeback register. Each of those three pipeline registers also supplies its instruction word. The block decodes the words to learn which register each older instruction writes, and replaces a stale source operand with the newer value that is already in flight.

The immediate operand is the low half of the execute-stage instruction word, sign-extended. The block does not stall anything. When a load is one instruction ahead of its consumer, the stall logic must hold the consumer. This block only ensures that such a load is never used as a forwarding source from the execute/memory register, and that an older writer of the same register behind it is not used either. All three outputs are registered, so they appear one clock after the inputs that produce them.

Top module: `fwdmux_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all three outputs become zero on that edge.
- R2: Outputs change only at the rising edge. Each output value reflects the inputs sampled at the previous rising edge.
- R3: Instruction words use these fields: opcode in bits [31:26], first source in [25:21], second source in [20:16], R-type destination in [15:11], immediate in [15:0]. Opcode 0x00 is an R-type ALU operation and writes [15:11]. Opcodes 0x08 to 0x0F are immediate ALU operations and write [20:16]. Opcode 0x23 is a load and writes [20:16]. Opcode 0x2B is a store, 0x04 and 0x05 are branches, and every other opcode is a no-op. None of these last groups writes a register.
- R4: If the execute/memory instruction is an ALU operation whose destination equals a nonzero source of the execute-stage instruction, that operand is the execute/memory ALU result.
- R5: If there is no execute/memory match and the memory/writeback instruction is an ALU operation whose destination equals the source, the operand is the memory/writeback ALU result.
- R6: If both pipeline registers write the same source register, the execute/memory instruction is the one used.
- R7: If there is no execute/memory match and the memory/writeback instruction is a load whose destination equals the source, the operand is the memory/writeback loaded word.
- R8: If the execute/memory instruction is a load that writes the source register, the operand is the plain register value (`idex_a` or `idex_b`), even when the memory/writeback instruction also matches.
- R9: A source register index of 0 always gives zero, whatever any stage writes.
- R10: Stores, branches and no-ops in either older stage are never forwarding sources, even when their [20:16] or [15:11] bits equal the source index.
- R11: The second ALU input is the forwarded second source only for R-type instructions. For every other instruction it is the sign-extended immediate, bits [15:0].
- R12: For a branch in the execute stage, the first ALU input is `idex_npc`. For every other instruction it is the forwarded first source.
- R13: If the execute/memory instruction is a store whose data register [20:16] is nonzero and equals the destination of an ALU operation in memory/writeback, the store data is the memory/writeback ALU result. A data register of 0 gives zero. In every other case, including a load in memory/writeback, the store data is `exmem_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idex_ir | input | 32 | Instruction word in the execute stage |
| idex_npc | input | DATA_W | Next-instruction address of the execute-stage instruction |
| idex_a | input | DATA_W | First source value read in decode |
| idex_b | input | DATA_W | Second source value read in decode |
| exmem_ir | input | 32 | Instruction word in the execute/memory register |
| exmem_alu | input | DATA_W | ALU result in the execute/memory register |
| exmem_b | input | DATA_W | Buffered store data in the execute/memory register |
| memwb_ir | input | 32 | Instruction word in the memory/writeback register |
| memwb_alu | input | DATA_W | ALU result in the memory/writeback register |
| memwb_lmd | input | DATA_W | Loaded word in the memory/writeback register |
| alu_in1 | output | DATA_W | First ALU operand (registered) |
| alu_in2 | output | DATA_W | Second ALU operand (registered) |
| store_data | output | DATA_W | Memory write data (registered) |

## Verification
The hardest case to reach is a load in execute/memory shadowing an older ALU or load writer of the same register in memory/writeback. Only a specific pair of opcodes and matching destination fields exposes whether the newer-but-unready load correctly suppresses forwarding. Directed vectors build that pair and its variants explicitly. These variants cover a matching R-type [15:11] against a non-matching [20:16], and a store whose [20:16] equals the source. A long random run then draws register indices from only four values, so that double matches, format mismatches and register-0 cases occur many times.

// File: rtl/fwdmux_pkg.sv
// Shared field positions, opcode values and the decoded-instruction record
// used by the forwarding unit. Assumes a fixed 32-bit three-register format.
package fwdmux_pkg;
    localparam int INSN_W    = 32;
    localparam int REG_IDX_W = 5;
    localparam int IMM_W     = 16;
    localparam int OPC_HI    = 31;
    localparam int OPC_LO    = 26;
    localparam int SRC1_HI   = 25;
    localparam int SRC1_LO   = 21;
    localparam int SRC2_HI   = 20;
    localparam int SRC2_LO   = 16;
    localparam int DSTR_HI   = 15;
    localparam int DSTR_LO   = 11;

    localparam logic [5:0] OPC_RTYPE  = 6'h00;
    localparam logic [2:0] OPC_IALU_G = 3'b001;   // opcodes 0x08..0x0F
    localparam logic [5:0] OPC_LOAD   = 6'h23;
    localparam logic [5:0] OPC_STORE  = 6'h2B;
    localparam logic [5:0] OPC_BRZ    = 6'h04;
    localparam logic [5:0] OPC_BRNZ   = 6'h05;

    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_RALU,
        CLS_IALU,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH
    } insn_cls_t;

    typedef struct packed {
        insn_cls_t cls;
        logic      wr_en;
        reg_idx_t  dst;
        reg_idx_t  src1;
        reg_idx_t  src2;
    } insn_info_t;

    // Classify one instruction word and extract its register fields.
    function automatic insn_info_t decode_insn(input logic [INSN_W-1:0] ir);
        insn_info_t d;
        logic [5:0] opc;
        opc    = ir[OPC_HI:OPC_LO];
        d.src1 = ir[SRC1_HI:SRC1_LO];
        d.src2 = ir[SRC2_HI:SRC2_LO];
        if (opc == OPC_RTYPE)
            d.cls = CLS_RALU;
        else if (opc[5:3] == OPC_IALU_G)
            d.cls = CLS_IALU;
        else if (opc == OPC_LOAD)
            d.cls = CLS_LOAD;
        else if (opc == OPC_STORE)
            d.cls = CLS_STORE;
        else if (opc == OPC_BRZ || opc == OPC_BRNZ)
            d.cls = CLS_BRANCH;
        else
            d.cls = CLS_NONE;
        d.wr_en = (d.cls == CLS_RALU) || (d.cls == CLS_IALU) || (d.cls == CLS_LOAD);
        if (!d.wr_en)
            d.dst = '0;
        else if (d.cls == CLS_RALU)
            d.dst = ir[DSTR_HI:DSTR_LO];
        else
            d.dst = ir[SRC2_HI:SRC2_LO];
        return d;
    endfunction
endpackage

// File: rtl/fwdmux_decode.sv
// Decodes the instruction word of every pipeline register handed to it.
// Assumes all words share the format in fwdmux_pkg; low function bits are unused.
module fwdmux_decode
    import fwdmux_pkg::*;
#(
    parameter int N_STAGES = 3
) (
    input  logic [N_STAGES-1:0][INSN_W-1:0] ir_vec,
    output insn_info_t [N_STAGES-1:0]       info_vec
);
    localparam int LOW_W = DSTR_LO;

    logic [N_STAGES-1:0][LOW_W-1:0] low_bits;
    logic unused_low_bits;

    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
        // Per-stage decode of class, destination and sources.
        always_comb info_vec[s] = decode_insn(ir_vec[s]);
        assign low_bits[s] = ir_vec[s][LOW_W-1:0];
    end

    assign unused_low_bits = ^low_bits;
endmodule

// File: rtl/fwdmux_src_sel.sv
// Chooses the freshest value for one execute-stage source register.
// Assumes older stages arrive pre-decoded; a load in execute/memory is not
// ready and masks any older match, leaving the register-file value.
module fwdmux_src_sel
    import fwdmux_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  reg_idx_t          src,
    input  logic [DATA_W-1:0] reg_val,
    input  insn_info_t        exmem_info,
    input  logic [DATA_W-1:0] exmem_alu,
    input  insn_info_t        memwb_info,
    input  logic [DATA_W-1:0] memwb_alu,
    input  logic [DATA_W-1:0] memwb_lmd,
    output logic [DATA_W-1:0] val
);
    logic ex_hit;
    logic wb_hit;

    // Destination comparison against each older stage.
    always_comb begin
        ex_hit = exmem_info.wr_en && (exmem_info.dst == src);
        wb_hit = memwb_info.wr_en && (memwb_info.dst == src);
    end

    // Priority: register 0, newest stage, older stage, register file.
    always_comb begin
        if (src == '0)
            val = '0;
        else if (ex_hit)
            val = (exmem_info.cls == CLS_LOAD) ? reg_val : exmem_alu;
        else if (wb_hit)
            val = (memwb_info.cls == CLS_LOAD) ? memwb_lmd : memwb_alu;
        else
            val = reg_val;
    end
endmodule

// File: rtl/fwdmux_store_sel.sv
// Picks the memory write data for a store in the memory stage.
// Assumes only an ALU result one instruction older is forwarded here.
module fwdmux_store_sel
    import fwdmux_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  insn_info_t        exmem_info,
    input  logic [DATA_W-1:0] exmem_b,
    input  insn_info_t        memwb_info,
    input  logic [DATA_W-1:0] memwb_alu,
    output logic [DATA_W-1:0] data
);
    logic wb_alu_writer;

    // Older instruction qualifies only if it is an ALU writer.
    always_comb wb_alu_writer = (memwb_info.cls == CLS_RALU) || (memwb_info.cls == CLS_IALU);

    // Store data choice: zero register, forwarded ALU result or buffered value.
    always_comb begin
        if (exmem_info.cls != CLS_STORE)
            data = exmem_b;
        else if (exmem_info.src2 == '0)
            data = '0;
        else if (wb_alu_writer && memwb_info.dst == exmem_info.src2)
            data = memwb_alu;
        else
            data = exmem_b;
    end
endmodule

// File: rtl/fwdmux_unit.sv
// Operand forwarding unit: registered ALU operands and store data.
// Assumes the hazard logic stalls load-use cases; this block never stalls.
module fwdmux_unit
    import fwdmux_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       idex_ir,
    input  logic [DATA_W-1:0] idex_npc,
    input  logic [DATA_W-1:0] idex_a,
    input  logic [DATA_W-1:0] idex_b,
    input  logic [31:0]       exmem_ir,
    input  logic [DATA_W-1:0] exmem_alu,
    input  logic [DATA_W-1:0] exmem_b,
    input  logic [31:0]       memwb_ir,
    input  logic [DATA_W-1:0] memwb_alu,
    input  logic [DATA_W-1:0] memwb_lmd,
    output logic [DATA_W-1:0] alu_in1,
    output logic [DATA_W-1:0] alu_in2,
    output logic [DATA_W-1:0] store_data
);
    localparam int N_STAGES  = 3;
    localparam int STG_IDEX  = 0;
    localparam int STG_EXMEM = 1;
    localparam int STG_MEMWB = 2;
    localparam int N_OPND    = 2;
    localparam int EXT_W     = DATA_W - IMM_W;

    logic [N_STAGES-1:0][INSN_W-1:0] ir_vec;
    insn_info_t [N_STAGES-1:0]       info;
    logic [N_OPND-1:0][REG_IDX_W-1:0] opnd_src;
    logic [N_OPND-1:0][DATA_W-1:0]    opnd_reg;
    logic [N_OPND-1:0][DATA_W-1:0]    opnd_fwd;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] st_sel;
    logic [DATA_W-1:0] in1_next;
    logic [DATA_W-1:0] in2_next;
    logic unused_info;

    assign ir_vec[STG_IDEX]  = idex_ir;
    assign ir_vec[STG_EXMEM] = exmem_ir;
    assign ir_vec[STG_MEMWB] = memwb_ir;

    fwdmux_decode #(.N_STAGES(N_STAGES)) u_decode (
        .ir_vec   (ir_vec),
        .info_vec (info)
    );

    assign opnd_src[0] = info[STG_IDEX].src1;
    assign opnd_src[1] = info[STG_IDEX].src2;
    assign opnd_reg[0] = idex_a;
    assign opnd_reg[1] = idex_b;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        fwdmux_src_sel #(.DATA_W(DATA_W)) u_sel (
            .src        (opnd_src[g]),
            .reg_val    (opnd_reg[g]),
            .exmem_info (info[STG_EXMEM]),
            .exmem_alu  (exmem_alu),
            .memwb_info (info[STG_MEMWB]),
            .memwb_alu  (memwb_alu),
            .memwb_lmd  (memwb_lmd),
            .val        (opnd_fwd[g])
        );
    end

    fwdmux_store_sel #(.DATA_W(DATA_W)) u_store (
        .exmem_info (info[STG_EXMEM]),
        .exmem_b    (exmem_b),
        .memwb_info (info[STG_MEMWB]),
        .memwb_alu  (memwb_alu),
        .data       (st_sel)
    );

    // Sign-extend the execute-stage immediate to the datapath width.
    always_comb imm_ext = {{EXT_W{idex_ir[IMM_W-1]}}, idex_ir[IMM_W-1:0]};

    // Format-dependent operand steering ahead of the output registers.
    always_comb begin
        in1_next = (info[STG_IDEX].cls == CLS_BRANCH) ? idex_npc : opnd_fwd[0];
        in2_next = (info[STG_IDEX].cls == CLS_RALU)   ? opnd_fwd[1] : imm_ext;
    end

    // Output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alu_in1    <= '0;
            alu_in2    <= '0;
            store_data <= '0;
        end else begin
            alu_in1    <= in1_next;
            alu_in2    <= in2_next;
            store_data <= st_sel;
        end
    end

    assign unused_info = ^{info[STG_IDEX].wr_en, info[STG_IDEX].dst,
                           info[STG_EXMEM].src1, info[STG_MEMWB].src1,
                           info[STG_MEMWB].src2};
endmodule

// File: rtl/fwdmux_unit_chk.sv
// Property checker for fwdmux_unit, attached by bind below.
// Re-derives instruction classes from the raw words and relates the sampled
// inputs to the registered outputs one clock later.
module fwdmux_unit_chk
    import fwdmux_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       idex_ir,
    input logic [DATA_W-1:0] idex_npc,
    input logic [DATA_W-1:0] idex_a,
    input logic [31:0]       exmem_ir,
    input logic [DATA_W-1:0] exmem_alu,
    input logic [31:0]       memwb_ir,
    input logic [DATA_W-1:0] memwb_alu,
    input logic [DATA_W-1:0] memwb_lmd,
    input logic [DATA_W-1:0] alu_in1,
    input logic [DATA_W-1:0] alu_in2,
    input logic [DATA_W-1:0] store_data
);
    logic [5:0] id_op, ex_op, wb_op;
    logic [4:0] id_rs1, ex_dst, wb_dst, st_reg;
    logic id_branch, id_rtype;
    logic ex_alu, ex_wr, ex_store, wb_alu, wb_load, wb_wr;
    logic [DATA_W-1:0] imm_sx;
    logic unused_chk;

    // Independent field extraction and classification.
    always_comb begin
        id_op     = idex_ir[31:26];
        ex_op     = exmem_ir[31:26];
        wb_op     = memwb_ir[31:26];
        id_rs1    = idex_ir[25:21];
        id_branch = (id_op == 6'h04) || (id_op == 6'h05);
        id_rtype  = (id_op == 6'h00);
        ex_alu    = (ex_op == 6'h00) || (ex_op >= 6'h08 && ex_op <= 6'h0F);
        ex_wr     = ex_alu || (ex_op == 6'h23);
        ex_store  = (ex_op == 6'h2B);
        ex_dst    = (ex_op == 6'h00) ? exmem_ir[15:11] : exmem_ir[20:16];
        st_reg    = exmem_ir[20:16];
        wb_alu    = (wb_op == 6'h00) || (wb_op >= 6'h08 && wb_op <= 6'h0F);
        wb_load   = (wb_op == 6'h23);
        wb_wr     = wb_alu || wb_load;
        wb_dst    = (wb_op == 6'h00) ? memwb_ir[15:11] : memwb_ir[20:16];
        imm_sx    = DATA_W'($signed(idex_ir[15:0]));
    end

    assign unused_chk = ^{idex_ir[20:16], exmem_ir[25:21], exmem_ir[10:0],
                          memwb_ir[25:21], memwb_ir[10:0]};

    p_exmem_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_branch && id_rs1 != 5'd0 && ex_alu && ex_dst == id_rs1)
        |=> alu_in1 == $past(exmem_alu));

    p_load_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_branch && id_rs1 != 5'd0 && !(ex_wr && ex_dst == id_rs1)
         && wb_load && wb_dst == id_rs1)
        |=> alu_in1 == $past(memwb_lmd));

    p_zero_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_branch && id_rs1 == 5'd0) |=> alu_in1 == '0);

    p_no_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_branch && id_rs1 != 5'd0 && !ex_wr && !wb_wr)
        |=> alu_in1 == $past(idex_a));

    p_imm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_rtype) |=> alu_in2 == $past(imm_sx));

    p_branch_npc_r12: assert property (@(posedge clk) disable iff (!rst_n)
        id_branch |=> alu_in1 == $past(idex_npc));

    p_store_fwd_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_store && st_reg != 5'd0 && wb_alu && wb_dst == st_reg)
        |=> store_data == $past(memwb_alu));

    p_store_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_store && st_reg == 5'd0) |=> store_data == '0);
endmodule

bind fwdmux_unit fwdmux_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/fwdmux_unit_test.sv
module fwdmux_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] idex_ir = 32'h5400_0000, idex_npc = '0, idex_a = '0, idex_b = '0;
    logic [31:0] exmem_ir = 32'h5400_0000, exmem_alu = '0, exmem_b = '0;
    logic [31:0] memwb_ir = 32'h5400_0000, memwb_alu = '0, memwb_lmd = '0;
    logic [31:0] alu_in1, alu_in2, store_data;
    logic [31:0] last1 = '0, last2 = '0, lasts = '0;
    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    localparam logic [31:0] NOP = 32'h5400_0000;

    always #10 clk = ~clk;

    fwdmux_unit uut (
        .clk(clk), .rst_n(rst_n),
        .idex_ir(idex_ir), .idex_npc(idex_npc), .idex_a(idex_a), .idex_b(idex_b),
        .exmem_ir(exmem_ir), .exmem_alu(exmem_alu), .exmem_b(exmem_b),
        .memwb_ir(memwb_ir), .memwb_alu(memwb_alu), .memwb_lmd(memwb_lmd),
        .alu_in1(alu_in1), .alu_in2(alu_in2), .store_data(store_data)
    );

    function automatic logic [31:0] rt(int rd, int s1, int s2);
        return {6'h00, 5'(s1), 5'(s2), 5'(rd), 11'h020};
    endfunction

    function automatic logic [31:0] it(logic [5:0] op, int s1, int t, logic [15:0] imm);
        return {op, 5'(s1), 5'(t), imm};
    endfunction

    // 0 none, 1 R-ALU, 2 I-ALU, 3 load, 4 store, 5 branch
    function automatic int kind(logic [31:0] ir);
        case (ir[31:26])
            6'h00: return 1;
            6'h23: return 3;
            6'h2B: return 4;
            6'h04, 6'h05: return 5;
            default: return (ir[31:26] >= 6'h08 && ir[31:26] <= 6'h0F) ? 2 : 0;
        endcase
    endfunction

    function automatic int dest_of(logic [31:0] ir);
        int k = kind(ir);
        if (k == 1) return int'(ir[15:11]);
        if (k == 2 || k == 3) return int'(ir[20:16]);
        return -1;
    endfunction

    function automatic logic [31:0] pick(int src, logic [31:0] regv);
        if (src == 0) return '0;
        if (dest_of(exmem_ir) == src) return (kind(exmem_ir) == 3) ? regv : exmem_alu;
        if (dest_of(memwb_ir) == src) return (kind(memwb_ir) == 3) ? memwb_lmd : memwb_alu;
        return regv;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Inputs are set at a falling edge; results are compared one falling edge later.
    task automatic run(string req);
        logic [31:0] e1, e2, es;
        int r;
        e1 = (kind(idex_ir) == 5) ? idex_npc : pick(int'(idex_ir[25:21]), idex_a);
        e2 = (kind(idex_ir) == 1) ? pick(int'(idex_ir[20:16]), idex_b)
                                  : {{16{idex_ir[15]}}, idex_ir[15:0]};
        es = exmem_b;
        if (kind(exmem_ir) == 4) begin
            r = int'(exmem_ir[20:16]);
            if (r == 0) es = '0;
            else if (dest_of(memwb_ir) == r && (kind(memwb_ir) == 1 || kind(memwb_ir) == 2))
                es = memwb_alu;
        end
        @(posedge clk);
        @(negedge clk);
        check(req, "alu_in1", alu_in1, e1);
        check(req, "alu_in2", alu_in2, e2);
        check(req, "store_data", store_data, es);
        last1 = e1; last2 = e2; lasts = es;
    endtask

    task automatic set_vals();
        idex_npc = 32'h0000_1004; idex_a = 32'hA0A0_0001; idex_b = 32'hB0B0_0002;
        exmem_alu = 32'hE1E1_0003; exmem_b = 32'h5B5B_0004;
        memwb_alu = 32'hC3C3_0005; memwb_lmd = 32'hD4D4_0006;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        set_vals();
        idex_ir = rt(3, 5, 6); exmem_ir = rt(5, 1, 2);
        repeat (2) @(negedge clk);
        // R1: reset forces zero despite active inputs
        check("R1", "alu_in1", alu_in1, '0);
        check("R1", "alu_in2", alu_in2, '0);
        check("R1", "store_data", store_data, '0);
        rst_n = 1'b1;

        // R4: execute/memory R-type result to first source
        idex_ir = rt(3, 5, 6); exmem_ir = rt(5, 1, 2); memwb_ir = NOP; run("R4");
        // R4 with R3 format: immediate ALU writes [20:16], matched on second source
        idex_ir = rt(3, 7, 9); exmem_ir = it(6'h08, 1, 9, 16'h0010); run("R4");
        // R2: hold before the edge, then update after it
        idex_ir = rt(3, 9, 7); exmem_alu = 32'h1357_9BDF;
        #4;
        check("R2", "alu_in1 held", alu_in1, last1);
        check("R2", "alu_in2 held", alu_in2, last2);
        run("R2");
        set_vals();
        // R5: memwb ALU to second source
        idex_ir = rt(3, 4, 6); exmem_ir = NOP; memwb_ir = rt(6, 1, 1); run("R5");
        // R6: both match, newest wins
        idex_ir = rt(3, 5, 6); exmem_ir = rt(5, 0, 0); memwb_ir = rt(5, 2, 2); run("R6");
        // R7: loaded word forwarded
        idex_ir = rt(3, 5, 6); exmem_ir = NOP; memwb_ir = it(6'h23, 2, 5, 16'h0020); run("R7");
        // R8: load in exmem masks older ALU match
        idex_ir = rt(3, 5, 6); exmem_ir = it(6'h23, 2, 5, 16'h0008); memwb_ir = rt(5, 2, 2); run("R8");
        // R8: load in exmem masks older load match on second source
        idex_ir = rt(3, 1, 6); exmem_ir = it(6'h23, 2, 6, 16'h0008); memwb_ir = it(6'h23, 3, 6, 16'h0); run("R8");
        // R9: register 0 never forwarded
        idex_ir = rt(3, 0, 0); exmem_ir = rt(0, 1, 1); memwb_ir = it(6'h23, 1, 0, 16'h0); run("R9");
        // R10: store and branch are not sources
        idex_ir = rt(3, 5, 5); exmem_ir = it(6'h2B, 1, 5, 16'h0000); memwb_ir = it(6'h04, 5, 5, 16'h2800); run("R10");
        // R10 and R3: R-type [20:16] match without destination match; I-type [15:11] match
        idex_ir = rt(3, 5, 6); exmem_ir = rt(9, 1, 5); memwb_ir = it(6'h0A, 1, 2, 16'h3000); run("R10");
        // R11: negative immediate sign-extended for I-ALU, load
        idex_ir = it(6'h0C, 5, 2, 16'hFFF0); exmem_ir = rt(5, 1, 1); memwb_ir = NOP; run("R11");
        idex_ir = it(6'h23, 0, 2, 16'h7FFC); run("R11");
        // R12: branch takes NPC and immediate
        idex_ir = it(6'h05, 5, 0, 16'h8004); run("R12");
        // R13: store data from memwb ALU, not from load, and zero register
        exmem_ir = it(6'h2B, 1, 7, 16'h0); memwb_ir = rt(7, 1, 1); idex_ir = NOP; run("R13");
        memwb_ir = it(6'h09, 1, 7, 16'h0); run("R13");
        memwb_ir = it(6'h23, 1, 7, 16'h0); run("R13");
        exmem_ir = it(6'h2B, 1, 0, 16'h0); memwb_ir = rt(0, 1, 1); run("R13");
        // R1: reset in the middle of traffic
        rst_n = 1'b0; idex_ir = rt(3, 5, 6); exmem_ir = rt(5, 1, 1);
        @(posedge clk); @(negedge clk);
        check("R1", "alu_in1 mid", alu_in1, '0);
        check("R1", "store_data mid", store_data, '0);
        rst_n = 1'b1;

        // Random mix over four registers: R4 R5 R6 R7 R8 R9 R10 R11 R12 R13
        for (int n = 0; n < 400; n++) begin
            logic [31:0] w [3];
            for (int s = 0; s < 3; s++) begin
                int a = $urandom_range(3), b = $urandom_range(3), d = $urandom_range(3);
                case ($urandom_range(6))
                    0, 1: w[s] = rt(d, a, b);
                    2: w[s] = it(6'h0A, a, b, 16'($urandom) | 16'(d << 11));
                    3: w[s] = it(6'h23, a, b, 16'($urandom));
                    4: w[s] = it(6'h2B, a, b, 16'(d << 11));
                    5: w[s] = it(6'h04, a, b, 16'($urandom));
                    default: w[s] = NOP | 32'(d << 11);
                endcase
            end
            idex_ir = w[0]; exmem_ir = w[1]; memwb_ir = w[2];
            idex_npc = $urandom; idex_a = $urandom; idex_b = $urandom;
            exmem_alu = $urandom; exmem_b = $urandom;
            memwb_alu = $urandom; memwb_lmd = $urandom;
            run("R6 mix");
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule